// File: doc/BRIEF.md
# Serializing Issue Gate

This block sits at one stage of an in-order, multi-threaded pipeline and decides in each cycle whether the instruction presented there may advance or has to wait. It applies two ordering rules, and it keeps the state for each hardware thread separately.

The first rule handles serializing instructions. An instruction that must drain the pipeline ahead of itself waits until it is the oldest instruction in flight on its thread. A control-register access follows the same rule. An instruction that must drain the pipeline behind itself does not wait. It records its own sequence number instead. The first younger instruction on that thread is then treated as drain-ahead. That promotion is reported on an output marker so that upstream logic can keep it with the instruction.

The second rule handles non-speculative instructions. Once such an instruction is allowed through, it raises a barrier on its thread. Every younger instruction on that thread stalls until a graduation notice names the barrier's thread and sequence number.

Top module: `serial_issue_gate`

## Requirements
- R1: An instruction with `req_ser_before` set, or with `req_ctrl_acc` set, or one promoted under R3, stalls whenever `req_oldest` is low. It is not stalled by this rule when `req_oldest` is high.
- R2: An instruction with `req_ser_after` or `req_store_cond` set that is not stalled by R1 sets the pending-serialization flag of its thread and records its own sequence number. It is not stalled by that flag.
- R3: When the pending flag of a thread is set, an instruction on that thread whose sequence number is strictly greater than the recorded one is promoted to drain-ahead. `fwd_ser_before` is high for it, and the pending flag clears on that clock edge even if the instruction stalls. An instruction with an equal or smaller number is not promoted. `fwd_ser_before` is high whenever a valid instruction carries `req_ser_before` or is promoted.
- R4: An instruction with `req_fault` set that is not stalled by R1 proceeds at once. The non-speculative barrier does not apply to it, and it never raises a barrier itself.
- R5: While a thread's barrier is active, an instruction on that thread whose sequence number is strictly greater than the barrier's number stalls. One with an equal or smaller number is not stalled by the barrier.
- R6: An instruction with `req_nonspec` set that proceeds raises the barrier of its thread and records its own sequence number. A non-speculative instruction that stalls changes nothing.
- R7: A graduation notice clears a thread's barrier only when `grad_tid` and `grad_seq` both match the active barrier. A notice that does not match has no effect.
- R8: The state of each thread changes only when that thread's own instructions or graduations act on it. Instructions on another thread are never stalled or promoted by it.
- R9: A synchronous active-high reset clears all pending and barrier flags. The decision is combinational in the current cycle. `req_go` and `req_stall` are never both high, and with `req_valid` low all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | An instruction is presented this cycle |
| req_tid | input | 1 | Hardware thread of the instruction |
| req_seq | input | 16 | Sequence number, unsigned, larger is younger |
| req_ser_before | input | 1 | Instruction must be oldest before it proceeds |
| req_ser_after | input | 1 | Younger instruction must wait for the pipeline to drain |
| req_store_cond | input | 1 | Conditional store, handled like req_ser_after |
| req_ctrl_acc | input | 1 | Control-register access, handled like req_ser_before |
| req_nonspec | input | 1 | Non-speculative instruction, raises the thread barrier |
| req_fault | input | 1 | Instruction carries a fault |
| req_oldest | input | 1 | Instruction is the oldest in flight on its thread |
| grad_valid | input | 1 | A graduation notice is present |
| grad_tid | input | 1 | Thread of the graduating instruction |
| grad_seq | input | 16 | Sequence number of the graduating instruction |
| req_go | output | 1 | Instruction may proceed |
| req_stall | output | 1 | Instruction must stall |
| fwd_ser_before | output | 1 | Instruction is to be treated as drain-ahead |

## Verification
The hardest situation to reach from the ports is a promotion that collides with other rules on the same instruction. Examples are a promoted instruction that is not oldest and stalls while its pending flag still clears, and a promoted instruction that is itself drain-behind and so sets the flag again. Graduation notices that miss by thread or by sequence number while a barrier is active are just as hard to reach. The directed sequences walk through these orderings on one thread while the other thread keeps running. The random phase draws sequence numbers from a narrow range, so equal and greater comparisons occur often. It also picks graduation numbers from the bench's own record of active barriers about half the time.

// File: rtl/ig_pkg.sv
package ig_pkg;

    // Attribute flags of the presented instruction
    typedef struct packed {
        logic ser_before;
        logic ser_after;
        logic store_cond;
        logic ctrl_acc;
        logic nonspec;
        logic fault;
    } ig_attr_t;

    // Decision and state-update strobes for the selected thread
    typedef struct packed {
        logic go;
        logic stall;
        logic mark_sb;
        logic set_pend;
        logic clr_pend;
        logic set_ns;
    } ig_act_t;

    // Reason for the decision, for readability of the decide stage
    typedef enum logic [2:0] {
        IG_IDLE,
        IG_SERIAL_WAIT,
        IG_FAULT_PASS,
        IG_BARRIER_WAIT,
        IG_PASS
    } ig_cause_e;

    function automatic logic drains_behind(input ig_attr_t a);
        return a.ser_after | a.store_cond;
    endfunction

endpackage

// File: rtl/ig_thread_state.sv
module ig_thread_state #(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             set_pend,
    input  logic             clr_pend,
    input  logic             set_ns,
    input  logic [SEQ_W-1:0] seq,
    input  logic             grad_sel,
    input  logic [SEQ_W-1:0] grad_seq,
    output logic             pend,
    output logic [SEQ_W-1:0] pend_seq,
    output logic             ns_act,
    output logic [SEQ_W-1:0] ns_seq
);

    logic grad_match;
    assign grad_match = grad_sel & ns_act & (grad_seq == ns_seq);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            pend_seq <= '0;
            ns_act   <= 1'b0;
            ns_seq   <= '0;
        end else begin
            if (hit && clr_pend) pend <= 1'b0;
            if (hit && set_pend) begin
                pend     <= 1'b1;
                pend_seq <= seq;
            end
            if (grad_match) ns_act <= 1'b0;
            if (hit && set_ns) begin
                ns_act <= 1'b1;
                ns_seq <= seq;
            end
        end
    end

    // R2: recording of a drain-behind instruction
    p_pend_record_r2: assert property (@(posedge clk) disable iff (rst)
        (hit && set_pend) |=> (pend && pend_seq == $past(seq)));

    // R3: promotion clears the flag unless it is set again
    p_promote_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (hit && clr_pend && !set_pend) |=> !pend);

    // R7: a matching graduation drops the barrier
    p_grad_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (grad_sel && ns_act && grad_seq == ns_seq && !(hit && set_ns)) |=> !ns_act);

    // R8: an untouched thread keeps its state
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!hit && !grad_sel) |=> ($stable(pend) && $stable(pend_seq) &&
                                 $stable(ns_act) && $stable(ns_seq)));

endmodule

// File: rtl/ig_decide.sv
module ig_decide
    import ig_pkg::*;
#(
    parameter int SEQ_W = 16
) (
    input  logic             valid,
    input  ig_attr_t         attr,
    input  logic [SEQ_W-1:0] seq,
    input  logic             oldest,
    input  logic             pend,
    input  logic [SEQ_W-1:0] pend_seq,
    input  logic             ns_act,
    input  logic [SEQ_W-1:0] ns_seq,
    output ig_act_t          act
);

    logic      promote;
    logic      eff_sb;
    logic      ser_block;
    logic      bar_block;
    ig_cause_e cause;

    assign promote   = valid & pend & (seq > pend_seq);
    assign eff_sb    = attr.ser_before | promote;
    assign ser_block = (eff_sb | attr.ctrl_acc) & ~oldest;
    assign bar_block = ns_act & (seq > ns_seq);

    always_comb begin
        if (!valid)          cause = IG_IDLE;
        else if (ser_block)  cause = IG_SERIAL_WAIT;
        else if (attr.fault) cause = IG_FAULT_PASS;
        else if (bar_block)  cause = IG_BARRIER_WAIT;
        else                 cause = IG_PASS;
    end

    always_comb begin
        act          = '0;
        act.mark_sb  = valid & eff_sb;
        act.clr_pend = promote;
        act.set_pend = valid & ~ser_block & drains_behind(attr);
        unique case (cause)
            IG_SERIAL_WAIT,
            IG_BARRIER_WAIT: act.stall = 1'b1;
            IG_FAULT_PASS:   act.go    = 1'b1;
            IG_PASS: begin
                act.go     = 1'b1;
                act.set_ns = attr.nonspec;
            end
            default: act = '0;
        endcase
    end

endmodule

// File: rtl/serial_issue_gate.sv
module serial_issue_gate
    import ig_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int SEQ_W       = 16,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [TID_W-1:0] req_tid,
    input  logic [SEQ_W-1:0] req_seq,
    input  logic             req_ser_before,
    input  logic             req_ser_after,
    input  logic             req_store_cond,
    input  logic             req_ctrl_acc,
    input  logic             req_nonspec,
    input  logic             req_fault,
    input  logic             req_oldest,
    input  logic             grad_valid,
    input  logic [TID_W-1:0] grad_tid,
    input  logic [SEQ_W-1:0] grad_seq,
    output logic             req_go,
    output logic             req_stall,
    output logic             fwd_ser_before
);

    ig_attr_t         attr;
    ig_act_t          act;
    logic             th_pend     [NUM_THREADS];
    logic [SEQ_W-1:0] th_pend_seq [NUM_THREADS];
    logic             th_ns       [NUM_THREADS];
    logic [SEQ_W-1:0] th_ns_seq   [NUM_THREADS];
    logic             sel_pend;
    logic [SEQ_W-1:0] sel_pend_seq;
    logic             sel_ns;
    logic [SEQ_W-1:0] sel_ns_seq;
    logic             tid_ok;

    assign attr = '{ser_before: req_ser_before, ser_after: req_ser_after,
                    store_cond: req_store_cond, ctrl_acc: req_ctrl_acc,
                    nonspec: req_nonspec, fault: req_fault};

    assign tid_ok = (int'(req_tid) < NUM_THREADS);

    always_comb begin
        sel_pend     = 1'b0;
        sel_pend_seq = '0;
        sel_ns       = 1'b0;
        sel_ns_seq   = '0;
        for (int i = 0; i < NUM_THREADS; i++) begin
            if (int'(req_tid) == i) begin
                sel_pend     = th_pend[i];
                sel_pend_seq = th_pend_seq[i];
                sel_ns       = th_ns[i];
                sel_ns_seq   = th_ns_seq[i];
            end
        end
    end

    ig_decide #(.SEQ_W(SEQ_W)) u_decide (
        .valid    (req_valid & tid_ok),
        .attr     (attr),
        .seq      (req_seq),
        .oldest   (req_oldest),
        .pend     (sel_pend),
        .pend_seq (sel_pend_seq),
        .ns_act   (sel_ns),
        .ns_seq   (sel_ns_seq),
        .act      (act)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
        logic hit_t;
        logic gsel_t;
        assign hit_t  = req_valid & (int'(req_tid) == t);
        assign gsel_t = grad_valid & (int'(grad_tid) == t);
        ig_thread_state #(.SEQ_W(SEQ_W)) u_state (
            .clk      (clk),
            .rst      (rst),
            .hit      (hit_t),
            .set_pend (act.set_pend),
            .clr_pend (act.clr_pend),
            .set_ns   (act.set_ns),
            .seq      (req_seq),
            .grad_sel (gsel_t),
            .grad_seq (grad_seq),
            .pend     (th_pend[t]),
            .pend_seq (th_pend_seq[t]),
            .ns_act   (th_ns[t]),
            .ns_seq   (th_ns_seq[t])
        );
    end

    assign req_go         = act.go;
    assign req_stall      = act.stall;
    assign fwd_ser_before = act.mark_sb;

    // R9: decision is exclusive and quiet without a request
    p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_go, req_stall}));
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!req_go && !req_stall && !fwd_ser_before));

    // R1: drain-ahead instruction not oldest must wait
    p_sb_wait_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_ser_before || req_ctrl_acc) && !req_oldest) |-> req_stall);

    // R4: fault passes once serialization allows it
    p_fault_pass_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_fault && (req_oldest || (!fwd_ser_before && !req_ctrl_acc)))
        |-> req_go);

    // R3: explicit drain-ahead is always forwarded
    p_fwd_mark_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ser_before) |-> fwd_ser_before);

endmodule

// File: tb/sim_serial_issue_gate.sv
module sim_serial_issue_gate;

    localparam int NT = 2;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [0:0]    req_tid;
    logic [SW-1:0] req_seq;
    logic req_ser_before, req_ser_after, req_store_cond, req_ctrl_acc;
    logic req_nonspec, req_fault, req_oldest;
    logic          grad_valid;
    logic [0:0]    grad_tid;
    logic [SW-1:0] grad_seq;
    logic req_go, req_stall, fwd_ser_before;

    int n_checks = 0;
    int n_fail   = 0;

    // Bench model of per-thread state
    logic          m_pend [NT];
    logic [SW-1:0] m_pseq [NT];
    logic          m_ns   [NT];
    logic [SW-1:0] m_nseq [NT];

    always #10 clk = ~clk;

    serial_issue_gate #(.NUM_THREADS(NT), .SEQ_W(SW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_tid(req_tid),
        .req_seq(req_seq), .req_ser_before(req_ser_before),
        .req_ser_after(req_ser_after), .req_store_cond(req_store_cond),
        .req_ctrl_acc(req_ctrl_acc), .req_nonspec(req_nonspec),
        .req_fault(req_fault), .req_oldest(req_oldest),
        .grad_valid(grad_valid), .grad_tid(grad_tid), .grad_seq(grad_seq),
        .req_go(req_go), .req_stall(req_stall), .fwd_ser_before(fwd_ser_before)
    );

    task automatic model_clear();
        for (int i = 0; i < NT; i++) begin
            m_pend[i] = 1'b0; m_pseq[i] = '0; m_ns[i] = 1'b0; m_nseq[i] = '0;
        end
    endtask

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check mid-phase, update model, wait next negedge
    task automatic step(input logic v, input int t, input int s,
                        input logic sb, input logic sa, input logic sc,
                        input logic cr, input logic ns, input logic ft,
                        input logic ol, input logic gv, input int gt,
                        input int gs, input string tag);
        logic prom, esb, eblk, bar, eg, est, efwd;
        string lbl;
        req_valid = v; req_tid = 1'(t); req_seq = SW'(s);
        req_ser_before = sb; req_ser_after = sa; req_store_cond = sc;
        req_ctrl_acc = cr; req_nonspec = ns; req_fault = ft; req_oldest = ol;
        grad_valid = gv; grad_tid = 1'(gt); grad_seq = SW'(gs);
        #2;
        prom = v && m_pend[t] && (SW'(s) > m_pseq[t]);
        esb  = sb || prom;
        eblk = (esb || cr) && !ol;
        bar  = m_ns[t] && (SW'(s) > m_nseq[t]);
        eg = 1'b0; est = 1'b0; efwd = v && esb;
        if (v) begin
            if (eblk) est = 1'b1;
            else if (ft) eg = 1'b1;
            else if (bar) est = 1'b1;
            else eg = 1'b1;
        end
        if (tag != "") lbl = tag;
        else if (!v) lbl = "R9";
        else if (eblk) lbl = "R1";
        else if (ft) lbl = "R4";
        else if (bar) lbl = "R5";
        else lbl = "R6";
        check(lbl, "go", req_go, eg);
        check(lbl, "stall", req_stall, est);
        check((tag != "") ? tag : "R3", "fwd_ser_before", fwd_ser_before, efwd);
        // model update in edge order
        if (prom) m_pend[t] = 1'b0;
        if (v && !eblk && (sa || sc)) begin m_pend[t] = 1'b1; m_pseq[t] = SW'(s); end
        if (gv && m_ns[gt] && m_nseq[gt] == SW'(gs)) m_ns[gt] = 1'b0;
        if (eg && !ft && ns) begin m_ns[t] = 1'b1; m_nseq[t] = SW'(s); end
        @(negedge clk);
    endtask

    task automatic plain(input int t, input int s, input logic ol, input string tag);
        step(1, t, s, 0, 0, 0, 0, 0, 0, ol, 0, 0, 0, tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req_valid = 0; grad_valid = 0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        req_tid = 0; req_seq = 0; req_ser_before = 0; req_ser_after = 0;
        req_store_cond = 0; req_ctrl_acc = 0; req_nonspec = 0; req_fault = 0;
        req_oldest = 0; grad_tid = 0; grad_seq = 0;
        model_clear();
        @(negedge clk);
        do_reset();

        // R9: idle and reset state
        step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        plain(0, 100, 0, "R9");
        plain(1, 100, 0, "R9");

        // R1: drain-ahead and control access
        step(1, 0, 5, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        step(1, 0, 5, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R1");
        step(1, 0, 6, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R1");
        step(1, 0, 6, 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, "R1");

        // R2 / R3: drain-behind and promotion
        step(1, 0, 20, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        plain(0, 20, 0, "R3");
        plain(0, 21, 0, "R3");
        plain(0, 22, 0, "R3");
        // R2 via conditional store, R8 other thread untouched
        step(1, 0, 30, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
        plain(1, 40, 0, "R8");
        plain(0, 31, 1, "R3");
        plain(0, 32, 0, "R3");
        // R3: promoted instruction that is itself drain-behind re-arms
        step(1, 0, 33, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 0, 34, 0, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R3");
        plain(0, 35, 0, "R3");
        // R2: drain-behind stalled by R1 does not arm
        step(1, 0, 36, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        plain(0, 37, 0, "R2");

        // R6 / R5 / R7 barrier
        step(1, 0, 50, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R6");
        plain(0, 51, 0, "R5");
        plain(0, 50, 0, "R5");
        plain(0, 49, 0, "R5");
        plain(1, 60, 0, "R8");
        step(1, 0, 52, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 50, "R7");
        plain(0, 51, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 49, "R7");
        plain(0, 51, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 50, "R7");
        plain(0, 51, 0, "R7");
        // R6: stalled non-speculative leaves state alone
        step(1, 0, 80, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, "R6");
        step(1, 0, 90, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R6");
        plain(0, 85, 0, "R6");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 80, "R7");

        // R4: fault ordering
        step(1, 0, 70, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R4");
        step(1, 0, 71, 0, 1, 0, 0, 1, 1, 0, 0, 0, 0, "R4");
        plain(0, 72, 0, "R4");
        plain(0, 73, 0, "R4");

        // R9: reset clears state mid-run
        step(1, 1, 10, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, "R9");
        do_reset();
        plain(1, 11, 0, "R9");

        // Random phase
        void'($urandom(32'd7531));
        for (int k = 0; k < 4000; k++) begin
            int t, s, gt, gs;
            logic gv;
            t  = int'($urandom_range(0, NT - 1));
            s  = int'($urandom_range(0, 15));
            gt = int'($urandom_range(0, NT - 1));
            gv = ($urandom_range(0, 3) == 0);
            gs = ($urandom_range(0, 1) == 0) ? int'(m_nseq[gt]) : int'($urandom_range(0, 15));
            step($urandom_range(0, 7) != 0, t, s,
                 $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
                 $urandom_range(0, 11) == 0, $urandom_range(0, 11) == 0,
                 $urandom_range(0, 7) == 0, $urandom_range(0, 11) == 0,
                 $urandom_range(0, 1) == 0, gv, gt, gs, "");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule